// File: doc/BRIEF.md
# Cross-Thread Oldest and Youngest Entry Selector

In a multithreaded out-of-order core each hardware thread keeps its own in-order list of in-flight instructions. Commit and squash logic still has to know which of those lists holds the globally oldest instruction and which holds the globally youngest one. This block answers that question. It compares the sequence number at the front of every thread's list, and the sequence number at the back of every thread's list, across all threads that are both enabled and non-empty.

The block reports three things. It gives the thread owning the oldest front entry, the thread owning the youngest back entry, and a flag that is raised when at least one enabled, non-empty thread has a front entry that is ready to commit. The block holds no instruction storage and performs no retirement. The surrounding list logic supplies the per-thread summaries, and the block only ranks them.

A parameter selects the output timing. The outputs can be purely combinational, or they can pass through one register stage so the block can sit on a timing-critical path.

Top module: `tos_select`

## Requirements
- R1: A thread takes part in the oldest-entry choice only when its bit in `thr_active` is 1 and its bit in `thr_empty` is 0. Whenever at least one thread qualifies, `old_vld` is 1 and `old_tid` names a qualifying thread.
- R2: The same qualification applies to the youngest-entry choice. Whenever at least one thread qualifies, `young_vld` is 1 and `young_tid` names a qualifying thread.
- R3: `old_tid` is the qualifying thread with the numerically smallest front sequence number, compared as unsigned. When several threads share that smallest value, the lowest thread index wins.
- R4: `young_tid` is the qualifying thread with the numerically largest back sequence number, compared as unsigned. When several threads share that largest value, the lowest thread index wins.
- R5: When no thread qualifies, `old_vld` and `young_vld` are both 0, and `old_tid` and `young_tid` are both 0.
- R6: `commit_ok` is 1 exactly when some thread has active=1, empty=0 and ready=1. A ready bit on an empty or disabled thread has no effect.
- R7: With `OUT_REG`=1 (the default), every output reflects the inputs present at the preceding rising clock edge. While `rst_n` is low, all outputs are 0.
- R8: With `OUT_REG`=0, the outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_active | input | NUM_THR | Per-thread enable, bit i for thread i |
| thr_empty | input | NUM_THR | Per-thread list-empty flag |
| thr_ready | input | NUM_THR | Per-thread front-entry ready-to-commit flag |
| head_seq | input | NUM_THR*SEQ_W | Front sequence numbers, thread i at bits [i*SEQ_W +: SEQ_W] |
| tail_seq | input | NUM_THR*SEQ_W | Back sequence numbers, same packing as head_seq |
| old_vld | output | 1 | A thread with the oldest front entry was found |
| old_tid | output | TID_W | Thread holding the globally oldest front entry |
| young_vld | output | 1 | A thread with the youngest back entry was found |
| young_tid | output | TID_W | Thread holding the globally youngest back entry |
| commit_ok | output | 1 | Some qualifying thread has a ready front entry |

## Verification
The bench goes after the qualification rules first: it places extreme sequence numbers on threads that are disabled or empty. A design that forgot to mask those threads would name the wrong thread, and would raise `commit_ok` from a stray ready bit. Ties get their own scenarios. A comparator using `<=` instead of `<`, or `>=` instead of `>`, would let a later thread overwrite an equal earlier one and report a higher index. The empty case checks that both valid bits drop. Two instances are compared against the same model, one registered and one combinational, so that an off-by-one-cycle output or a missing reset is exposed.

// File: rtl/tos_pkg.sv
package tos_pkg;

  // Direction in which a scan chain ranks sequence numbers.
  typedef enum logic {
    PICK_LOWEST  = 1'b0,
    PICK_HIGHEST = 1'b1
  } pick_dir_e;

  // Width of a thread index; never narrower than one bit.
  function automatic int unsigned tid_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tos_scan_chain.sv
// Linear priority scan: thread 0 seeds, later threads replace the running
// choice only on a strictly better sequence number.
module tos_scan_chain
  import tos_pkg::*;
#(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned SEQ_W   = 16,
  parameter int unsigned TID_W   = 2,
  parameter pick_dir_e   DIR     = PICK_LOWEST
) (
  input  logic [NUM_THR-1:0]       elig,
  input  logic [NUM_THR*SEQ_W-1:0] seq_flat,
  output logic                     pick_vld,
  output logic [TID_W-1:0]         pick_tid
);

  logic             st_vld [NUM_THR+1];
  logic [TID_W-1:0] st_tid [NUM_THR+1];
  logic [SEQ_W-1:0] st_seq [NUM_THR+1];

  assign st_vld[0] = 1'b0;
  assign st_tid[0] = '0;
  assign st_seq[0] = '0;

  for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_stage
    logic [SEQ_W-1:0] cand_seq;
    logic             better;
    logic             take;

    assign cand_seq = seq_flat[gi*SEQ_W +: SEQ_W];

    if (DIR == PICK_LOWEST) begin : g_low
      assign better = (cand_seq < st_seq[gi]);
    end else begin : g_high
      assign better = (cand_seq > st_seq[gi]);
    end

    assign take = elig[gi] & (~st_vld[gi] | better);

    assign st_vld[gi+1] = st_vld[gi] | elig[gi];
    assign st_tid[gi+1] = take ? TID_W'(gi) : st_tid[gi];
    assign st_seq[gi+1] = take ? cand_seq   : st_seq[gi];
  end

  assign pick_vld = st_vld[NUM_THR];
  assign pick_tid = st_vld[NUM_THR] ? st_tid[NUM_THR] : '0;

endmodule

// File: rtl/tos_commit_or.sv
// Qualification mask and the any-ready reduction.
module tos_commit_or #(
  parameter int unsigned NUM_THR = 4
) (
  input  logic [NUM_THR-1:0] thr_active,
  input  logic [NUM_THR-1:0] thr_empty,
  input  logic [NUM_THR-1:0] thr_ready,
  output logic [NUM_THR-1:0] elig,
  output logic               any_ready
);

  logic [NUM_THR-1:0] ready_elig;

  always_comb begin
    elig       = thr_active & ~thr_empty;
    ready_elig = elig & thr_ready;
    any_ready  = |ready_elig;
  end

endmodule

// File: rtl/tos_out_stage.sv
// Optional output register: a flop bank with async reset, or a wire.
module tos_out_stage #(
  parameter int unsigned WIDTH     = 8,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  if (REGISTERED) begin : g_reg
    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_nxt;
    logic             upd_en;

    assign upd_en = 1'b1;

    always_comb begin
      q_nxt = q_r;
      if (upd_en) q_nxt = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_nxt;
    end

    assign q = q_r;
  end else begin : g_wire
    assign q = d;
  end

endmodule

// File: rtl/tos_select.sv
module tos_select
  import tos_pkg::*;
#(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned SEQ_W   = 16,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned TID_W  = tid_width(NUM_THR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_THR-1:0]       thr_active,
  input  logic [NUM_THR-1:0]       thr_empty,
  input  logic [NUM_THR-1:0]       thr_ready,
  input  logic [NUM_THR*SEQ_W-1:0] head_seq,
  input  logic [NUM_THR*SEQ_W-1:0] tail_seq,
  output logic                     old_vld,
  output logic [TID_W-1:0]         old_tid,
  output logic                     young_vld,
  output logic [TID_W-1:0]         young_tid,
  output logic                     commit_ok
);

  localparam int unsigned BUNDLE_W = 2*TID_W + 3;

  logic [NUM_THR-1:0]  elig;
  logic                any_ready;
  logic                h_vld;
  logic [TID_W-1:0]    h_tid;
  logic                t_vld;
  logic [TID_W-1:0]    t_tid;
  logic [BUNDLE_W-1:0] bundle_d;
  logic [BUNDLE_W-1:0] bundle_q;

  tos_commit_or #(.NUM_THR(NUM_THR)) u_qual (
    .thr_active (thr_active),
    .thr_empty  (thr_empty),
    .thr_ready  (thr_ready),
    .elig       (elig),
    .any_ready  (any_ready)
  );

  tos_scan_chain #(
    .NUM_THR (NUM_THR),
    .SEQ_W   (SEQ_W),
    .TID_W   (TID_W),
    .DIR     (PICK_LOWEST)
  ) u_oldest (
    .elig     (elig),
    .seq_flat (head_seq),
    .pick_vld (h_vld),
    .pick_tid (h_tid)
  );

  tos_scan_chain #(
    .NUM_THR (NUM_THR),
    .SEQ_W   (SEQ_W),
    .TID_W   (TID_W),
    .DIR     (PICK_HIGHEST)
  ) u_youngest (
    .elig     (elig),
    .seq_flat (tail_seq),
    .pick_vld (t_vld),
    .pick_tid (t_tid)
  );

  assign bundle_d = {h_vld, h_tid, t_vld, t_tid, any_ready};

  tos_out_stage #(
    .WIDTH      (BUNDLE_W),
    .REGISTERED (OUT_REG)
  ) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bundle_d),
    .q     (bundle_q)
  );

  assign {old_vld, old_tid, young_vld, young_tid, commit_ok} = bundle_q;

endmodule

// File: rtl/tos_checker.sv
module tos_checker #(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned SEQ_W   = 16,
  parameter bit          OUT_REG = 1'b1,
  parameter int unsigned TID_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_THR-1:0]       thr_active,
  input logic [NUM_THR-1:0]       thr_empty,
  input logic [NUM_THR-1:0]       thr_ready,
  input logic [NUM_THR*SEQ_W-1:0] head_seq,
  input logic [NUM_THR*SEQ_W-1:0] tail_seq,
  input logic                     old_vld,
  input logic [TID_W-1:0]         old_tid,
  input logic                     young_vld,
  input logic [TID_W-1:0]         young_tid,
  input logic                     commit_ok
);

  logic [NUM_THR-1:0]       e_q;
  logic [NUM_THR-1:0]       r_q;
  logic [NUM_THR*SEQ_W-1:0] hs_q;
  logic [NUM_THR*SEQ_W-1:0] ts_q;
  logic                     primed;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        primed <= 1'b0;
        e_q    <= '0;
        r_q    <= '0;
        hs_q   <= '0;
        ts_q   <= '0;
      end else begin
        primed <= 1'b1;
        e_q    <= thr_active & ~thr_empty;
        r_q    <= thr_ready;
        hs_q   <= head_seq;
        ts_q   <= tail_seq;
      end
    end
  end else begin : g_now
    assign primed = 1'b1;
    assign e_q    = thr_active & ~thr_empty;
    assign r_q    = thr_ready;
    assign hs_q   = head_seq;
    assign ts_q   = tail_seq;
  end

  logic head_bad;
  logic tail_bad;
  logic [SEQ_W-1:0] sel_h;
  logic [SEQ_W-1:0] sel_t;

  always_comb begin
    sel_h    = hs_q[old_tid*SEQ_W +: SEQ_W];
    sel_t    = ts_q[young_tid*SEQ_W +: SEQ_W];
    head_bad = 1'b0;
    tail_bad = 1'b0;
    for (int i = 0; i < NUM_THR; i++) begin
      if (e_q[i]) begin
        if (hs_q[i*SEQ_W +: SEQ_W] < sel_h) head_bad = 1'b1;
        if ((i < int'(old_tid)) && (hs_q[i*SEQ_W +: SEQ_W] == sel_h)) head_bad = 1'b1;
        if (ts_q[i*SEQ_W +: SEQ_W] > sel_t) tail_bad = 1'b1;
        if ((i < int'(young_tid)) && (ts_q[i*SEQ_W +: SEQ_W] == sel_t)) tail_bad = 1'b1;
      end
    end
  end

  AST_HEAD_FROM_ELIG: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    old_vld |-> e_q[old_tid]) else $error("head from unqualified thread"); // R1

  AST_HEAD_PRESENT: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (e_q != '0) |-> old_vld) else $error("head missing"); // R1

  AST_TAIL_FROM_ELIG: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    young_vld |-> e_q[young_tid]) else $error("tail from unqualified thread"); // R2

  AST_TAIL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (e_q != '0) |-> young_vld) else $error("tail missing"); // R2

  AST_HEAD_OLDEST: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    old_vld |-> !head_bad) else $error("head not oldest"); // R3

  AST_TAIL_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    young_vld |-> !tail_bad) else $error("tail not youngest"); // R4

  AST_IDLE_NO_PICK: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (e_q == '0) |-> (!old_vld && !young_vld && old_tid == '0 && young_tid == '0))
    else $error("pick with no qualifying thread"); // R5

  AST_COMMIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    commit_ok == |(e_q & r_q)) else $error("commit flag mismatch"); // R6

endmodule

bind tos_select tos_checker #(
  .NUM_THR (NUM_THR),
  .SEQ_W   (SEQ_W),
  .OUT_REG (OUT_REG),
  .TID_W   (TID_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .thr_active (thr_active),
  .thr_empty  (thr_empty),
  .thr_ready  (thr_ready),
  .head_seq   (head_seq),
  .tail_seq   (tail_seq),
  .old_vld    (old_vld),
  .old_tid    (old_tid),
  .young_vld  (young_vld),
  .young_tid  (young_tid),
  .commit_ok  (commit_ok)
);

// File: tb/tos_select_tb.sv
module tos_select_tb;

  localparam int N  = 4;
  localparam int SW = 8;
  localparam int TW = 2;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  act, emp, rdy;
  logic [SW-1:0] hs [N];
  logic [SW-1:0] ts [N];
  logic [N*SW-1:0] hflat, tflat;

  logic          r_ov, r_yv, r_cc, c_ov, c_yv, c_cc;
  logic [TW-1:0] r_ot, r_yt, c_ot, c_yt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      hflat[i*SW +: SW] = hs[i];
      tflat[i*SW +: SW] = ts[i];
    end
  end

  tos_select #(.NUM_THR(N), .SEQ_W(SW), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_active(act), .thr_empty(emp), .thr_ready(rdy),
    .head_seq(hflat), .tail_seq(tflat),
    .old_vld(r_ov), .old_tid(r_ot), .young_vld(r_yv), .young_tid(r_yt), .commit_ok(r_cc));

  tos_select #(.NUM_THR(N), .SEQ_W(SW), .OUT_REG(1'b0)) u_comb (
    .clk(clk), .rst_n(rst_n), .thr_active(act), .thr_empty(emp), .thr_ready(rdy),
    .head_seq(hflat), .tail_seq(tflat),
    .old_vld(c_ov), .old_tid(c_ot), .young_vld(c_yv), .young_tid(c_yt), .commit_ok(c_cc));

  task automatic chk(input string req, input string what, input int actual, input int expct);
    n_chk++;
    if (actual != expct) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expct);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  // Reference ranking taken from the requirements.
  task automatic model(output bit hv, output int ht, output bit tv, output int tt, output bit cc);
    hv = 0; ht = 0; tv = 0; tt = 0; cc = 0;
    for (int i = 0; i < N; i++) begin
      if (act[i] && !emp[i]) begin
        if (!hv || hs[i] < hs[ht]) ht = i;
        if (!tv || ts[i] > ts[tt]) tt = i;
        hv = 1; tv = 1;
        if (rdy[i]) cc = 1;
      end
    end
  endtask

  // Inputs must already be set after a falling edge.
  task automatic apply(input string tag);
    bit hv, tv, cc;
    int ht, tt;
    model(hv, ht, tv, tt, cc);
    #2;
    chk({tag, "/R8"}, "comb old_vld",   int'(c_ov), int'(hv));
    chk({tag, "/R8"}, "comb old_tid",   int'(c_ot), ht);
    chk({tag, "/R8"}, "comb young_vld", int'(c_yv), int'(tv));
    chk({tag, "/R8"}, "comb young_tid", int'(c_yt), tt);
    chk({tag, "/R8"}, "comb commit_ok", int'(c_cc), int'(cc));
    @(posedge clk); #2;
    chk({tag, "/R7"}, "reg old_vld",   int'(r_ov), int'(hv));
    chk({tag, "/R7"}, "reg old_tid",   int'(r_ot), ht);
    chk({tag, "/R7"}, "reg young_vld", int'(r_yv), int'(tv));
    chk({tag, "/R7"}, "reg young_tid", int'(r_yt), tt);
    chk({tag, "/R7"}, "reg commit_ok", int'(r_cc), int'(cc));
    @(negedge clk);
  endtask

  task automatic set_seqs(input int h0, h1, h2, h3, input int t0, t1, t2, t3);
    hs[0] = SW'(h0); hs[1] = SW'(h1); hs[2] = SW'(h2); hs[3] = SW'(h3);
    ts[0] = SW'(t0); ts[1] = SW'(t1); ts[2] = SW'(t2); ts[3] = SW'(t3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    act = '1; emp = '0; rdy = '1;
    set_seqs(3, 1, 2, 4, 9, 8, 7, 6);
    repeat (3) @(posedge clk);
    #2;
    chk("R7", "reset old_vld",   int'(r_ov), 0);
    chk("R7", "reset old_tid",   int'(r_ot), 0);
    chk("R7", "reset young_vld", int'(r_yv), 0);
    chk("R7", "reset young_tid", int'(r_yt), 0);
    chk("R7", "reset commit_ok", int'(r_cc), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_no_threads();
    set_seqs(1, 2, 3, 4, 5, 6, 7, 8);
    rdy = '1;
    act = '1; emp = '1; apply("R5");
    act = '0; emp = '0; apply("R5");
    act = 4'b0011; emp = 4'b0011; apply("R5");
  endtask

  task automatic t_inactive_skip();
    act = 4'b1010; emp = '0; rdy = '0;
    set_seqs(5, 40, 1, 20, 250, 60, 255, 50);
    apply("R1");   // head thread 3, tail thread 1
    apply("R2");
  endtask

  task automatic t_empty_skip();
    act = '1; emp = 4'b0101; rdy = '0;
    set_seqs(5, 40, 1, 20, 250, 60, 255, 50);
    apply("R1");   // head 3, tail 1
    apply("R2");
  endtask

  task automatic t_ties();
    act = '1; emp = '0; rdy = '0;
    set_seqs(7, 7, 7, 7, 9, 9, 9, 9);
    apply("R3");   // head 0, tail 0
    set_seqs(9, 3, 3, 3, 1, 5, 5, 2);
    apply("R4");   // head 1, tail 1
    set_seqs(200, 150, 0, 0, 0, 0, 255, 255);
    apply("R3");   // head 2, tail 2
  endtask

  task automatic t_single();
    act = 4'b1000; emp = '0; rdy = 4'b1000;
    set_seqs(0, 0, 0, 99, 255, 255, 255, 10);
    apply("R3");
    apply("R4");
  endtask

  task automatic t_commit();
    set_seqs(1, 2, 3, 4, 1, 2, 3, 4);
    act = 4'b0111; emp = 4'b0001; rdy = 4'b1001;
    apply("R6");   // ready only on empty thread 0 and disabled thread 3
    rdy = 4'b0100;
    apply("R6");   // qualifying thread 2 ready
    rdy = '0;
    apply("R6");
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 300; k++) begin
      act = N'($urandom);
      emp = N'($urandom);
      rdy = N'($urandom);
      for (int i = 0; i < N; i++) begin
        hs[i] = (k % 2 == 0) ? SW'($urandom % 4) : SW'($urandom);
        ts[i] = (k % 2 == 0) ? SW'($urandom % 4) : SW'($urandom);
      end
      apply((k % 3 == 0) ? "R3" : ((k % 3 == 1) ? "R4" : "R6"));
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk);
    t_no_threads();
    t_inactive_skip();
    t_empty_skip();
    t_ties();
    t_single();
    t_commit();
    t_sweep();
    report();
    $finish;
  end

endmodule